// File: doc/BRIEF.md
# Rewindable Single-Clock Stream FIFO

This block is a first-in first-out buffer in one clock domain. It takes words on a valid/ready input stream and gives them out on a valid/ready output stream. Four status pins report how full it is: empty, full, almost-empty and almost-full. Two level inputs set the thresholds for the almost flags. The word count and the free space are both derived from the distance between a write pointer and a read pointer, and all four flags follow directly from that distance.

A static mode pin, `replay_mode`, chooses between two behaviours. With the pin low the buffer is an ordinary circular FIFO. With the pin high the write pointer never wraps: the block can take at most `DEPTH` words after reset, and nothing is ever written over the first stored word. In this mode a pulse on `rewind` sends the read pointer back to the first location, so every word written since reset can be read out again. Words written after the rewind come out after the replayed words. The rewind can be repeated as often as needed. It does not touch the write pointer.

Back-pressure rules: a word enters only on a cycle where `in_valid` and `in_ready` are both high. A word leaves only on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value. The source may hold `in_valid` high while `in_ready` is low; no word is taken in that case.

Top module: `rtx_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `out_valid`=0, `in_ready`=1, `almost_empty`=1, and `almost_full` equals (DEPTH <= `af_level`).
- R2: Words leave in the order they were accepted. `out_data` stays stable while `out_valid`=1 and `out_ready`=0.
- R3: `in_ready` is the inverse of `full`, and a write offered while full is dropped. In circular mode the block is full when it holds DEPTH words. In replay mode it is full once DEPTH words have been accepted since reset.
- R4: `empty` is 1 exactly when the held count is 0, and `out_valid` is then 0. A read offered while empty moves nothing.
- R5: `almost_empty` is 1 when the held count is at or below `ae_level`.
- R6: `almost_full` is 1 when the free space is at or below `af_level`. Free space is DEPTH minus the held count in circular mode, and DEPTH minus the words accepted since reset in replay mode.
- R7: In replay mode, a `rewind` pulse moves the read pointer to the first location. The next word out is the first word accepted since reset. The write pointer keeps its value.
- R8: In the cycle where a rewind takes effect, `out_valid` is 0, so no read happens in that cycle.
- R9: Words accepted after a rewind are read out after the replayed words, in their own order.
- R10: The cycle after a rewind, all four flags reflect the new distance between the pointers (the count of words accepted since reset).
- R11: The full DEPTH words can be replayed, and the rewind can be repeated any number of times.
- R12: In circular mode (`replay_mode`=0), `rewind` has no effect: reads carry on from where they were.
- R13: In circular mode the pointers wrap around, and space freed by reads can be written again without limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| replay_mode | input | 1 | 1 = non-wrapping rewindable mode, 0 = circular; held static out of reset |
| rewind | input | 1 | Pulse: rewind the read pointer (replay mode only) |
| ae_level | input | $clog2(DEPTH)+1 | Almost-empty threshold |
| af_level | input | $clog2(DEPTH)+1 | Almost-full threshold |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink takes the word |
| out_data | output | DATA_W | Output word |
| full | output | 1 | No free space |
| empty | output | 1 | Nothing held |
| almost_full | output | 1 | Free space at or below `af_level` |
| almost_empty | output | 1 | Held count at or below `ae_level` |

## Verification
The properties assume that `replay_mode` does not change while the block is out of reset. A live change would break the link between the pointer distance and the flags. The stimulus sets the mode only while reset is held, and it asserts reset again before each change of mode. The properties also assume that a source holding a word keeps presenting it. The stimulus changes its inputs only on the falling edge, so each handshake is judged on values that were stable across the rising edge.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;
  // Per-cycle pointer operations decided at the top level.
  typedef struct packed {
    logic wr;
    logic rd;
    logic rewind;
  } rtx_ops_t;
endpackage

// File: rtl/rtx_mem.sv
module rtx_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rows [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic [DATA_W-1:0] row_q;
    always_ff @(posedge clk) begin
      if (we && waddr == AW'(g)) row_q <= wdata;
    end
    assign rows[g] = row_q;
  end

  assign rdata = rows[raddr];
endmodule

// File: rtl/rtx_ptrs.sv
module rtx_ptrs
  import rtx_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rtx_ops_t      ops,
  output logic [CW-1:0] wr_ptr,
  output logic [CW-1:0] rd_ptr
);
  logic [CW-1:0] wr_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (ops.wr) wr_q <= wr_q + CW'(1);
      if (ops.rewind)  rd_q <= '0;
      else if (ops.rd) rd_q <= rd_q + CW'(1);
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;
endmodule

// File: rtl/rtx_flags.sv
module rtx_flags #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          replay_mode,
  input  logic [CW-1:0] wr_ptr,
  input  logic [CW-1:0] rd_ptr,
  input  logic [CW-1:0] ae_level,
  input  logic [CW-1:0] af_level,
  output logic          full,
  output logic          empty,
  output logic          almost_full,
  output logic          almost_empty
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [CW-1:0] held, room;

  always_comb begin
    held = wr_ptr - rd_ptr;
    // In replay mode the write side never wraps, so room is what remains
    // above the write pointer, whatever the reader has consumed.
    room = replay_mode ? (CAP - wr_ptr) : (CAP - held);
    empty        = (held == '0);
    full         = (room == '0);
    almost_empty = (held <= ae_level);
    almost_full  = (room <= af_level);
  end
endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo
  import rtx_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              replay_mode,
  input  logic              rewind,
  input  logic [CW-1:0]     ae_level,
  input  logic [CW-1:0]     af_level,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              full,
  output logic              empty,
  output logic              almost_full,
  output logic              almost_empty
);
  rtx_ops_t      ops;
  logic [CW-1:0] wr_ptr_w, rd_ptr_w;
  logic          full_w, empty_w, rewind_eff;

  assign rewind_eff = rewind & replay_mode;
  assign in_ready   = ~full_w;
  assign out_valid  = ~empty_w & ~rewind_eff;

  always_comb begin
    ops.wr     = in_valid & ~full_w;
    ops.rd     = out_valid & out_ready;
    ops.rewind = rewind_eff;
  end

  rtx_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ops    (ops),
    .wr_ptr (wr_ptr_w),
    .rd_ptr (rd_ptr_w)
  );

  rtx_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) mem_i (
    .clk   (clk),
    .we    (ops.wr),
    .waddr (wr_ptr_w[AW-1:0]),
    .wdata (in_data),
    .raddr (rd_ptr_w[AW-1:0]),
    .rdata (out_data)
  );

  rtx_flags #(.DEPTH(DEPTH)) flags_i (
    .replay_mode  (replay_mode),
    .wr_ptr       (wr_ptr_w),
    .rd_ptr       (rd_ptr_w),
    .ae_level     (ae_level),
    .af_level     (af_level),
    .full         (full_w),
    .empty        (empty_w),
    .almost_full  (almost_full),
    .almost_empty (almost_empty)
  );

  assign full  = full_w;
  assign empty = empty_w;
endmodule

// File: rtl/rtx_fifo_chk.sv
module rtx_fifo_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       replay_mode,
  input logic                       rewind,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [DATA_W-1:0]          out_data,
  input logic                       full,
  input logic                       empty,
  input logic [$clog2(DEPTH):0]     wr_ptr,
  input logic [$clog2(DEPTH):0]     rd_ptr
);
  localparam int CW = $clog2(DEPTH) + 1;

  // Input assumption: the mode pin is static while out of reset.
  a_mode_static: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(replay_mode));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !out_valid);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full && in_valid && !(out_valid && out_ready) |=> full && $stable(wr_ptr));

  p_hold_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data) && (out_valid || rewind));

  p_rewind_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rewind && replay_mode |=> rd_ptr == '0);

  p_wr_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rewind && replay_mode && !(in_valid && in_ready) |=> $stable(wr_ptr));

  p_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    replay_mode |-> wr_ptr <= CW'(DEPTH));
endmodule

bind rtx_fifo rtx_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .replay_mode (replay_mode),
  .rewind      (rewind),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .full        (full),
  .empty       (empty),
  .wr_ptr      (wr_ptr_w),
  .rd_ptr      (rd_ptr_w)
);

// File: tb/rtx_fifo_tb_top.sv
`timescale 1ns/1ps
module rtx_fifo_tb_top;
  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam int AE    = 2;
  localparam int AF    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic replay_mode = 1'b0;
  logic rewind = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, full, empty, almost_full, almost_empty;
  logic [DW-1:0] out_data;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string data_tag = "R2";
  logic [DW-1:0] hist [$];
  int rd_idx = 0;
  int seq = 0;

  always #2.5 clk = ~clk;

  rtx_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .replay_mode(replay_mode), .rewind(rewind),
    .ae_level(CW'(AE)), .af_level(CW'(AF)),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .full(full), .empty(empty), .almost_full(almost_full), .almost_empty(almost_empty)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Inputs change on the falling edge only.
  task automatic drive(input bit iv, input bit ordy, input bit rw);
    @(negedge clk);
    in_valid  = iv;
    in_data   = DW'(16'hA000 + seq);
    if (iv) seq++;
    out_ready = ordy;
    rewind    = rw;
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 1'b0; replay_mode = mode;
    in_valid = 0; out_ready = 0; rewind = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(empty == 1, "R1", "empty", empty, 1);
    chk(full == 0, "R1", "full", full, 0);
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready", in_ready, 1);
    chk(almost_empty == 1, "R1", "almost_empty", almost_empty, 1);
    chk(almost_full == (DEPTH <= AF), "R1", "almost_full", almost_full, DEPTH <= AF);
  endtask

  // Scoreboard monitor: sampled 0.5 ns before each rising edge.
  always begin
    int cnt, room, exp_valid;
    bit rw_eff;
    @(negedge clk); #2;
    if (!rst_n) begin
      hist.delete(); rd_idx = 0;
    end else begin
      cnt    = hist.size() - rd_idx;
      room   = replay_mode ? DEPTH - hist.size() : DEPTH - cnt;
      rw_eff = rewind && replay_mode;
      exp_valid = (cnt > 0) && !rw_eff;
      chk(empty == (cnt == 0), "R4", "empty", empty, cnt == 0);
      chk(full == (room == 0), "R3", "full", full, room == 0);
      chk(in_ready == (room != 0), "R3", "in_ready", in_ready, room != 0);
      chk(almost_empty == (cnt <= AE), "R5", "almost_empty", almost_empty, cnt <= AE);
      chk(almost_full == (room <= AF), "R6", "almost_full", almost_full, room <= AF);
      chk(out_valid == exp_valid, rw_eff ? "R8" : "R4", "out_valid", out_valid, exp_valid);
      if (out_valid && out_ready) begin
        if (rd_idx < hist.size()) begin
          chk(out_data == hist[rd_idx], data_tag, "out_data", out_data, hist[rd_idx]);
          rd_idx++;
        end
      end
      if (rw_eff) rd_idx = 0;
      if (in_valid && in_ready) hist.push_back(in_data);
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // ---- circular mode ----
    do_reset(1'b0);
    data_tag = "R2";
    for (int i = 0; i < DEPTH; i++) drive(1, 0, 0);
    drive(1, 0, 0);                       // offered while full
    #1 chk(in_ready == 0, "R3", "in_ready when full", in_ready, 0);
    data_tag = "R12";
    drive(0, 1, 1);                       // rewind ignored in circular mode
    drive(0, 1, 0);
    drive(0, 0, 0);
    drive(0, 1, 0);
    data_tag = "R13";
    for (int i = 0; i < 24; i++) drive(i % 3 != 0, i % 2 == 0, 0);
    for (int i = 0; i < 12; i++) drive(0, 1, 0);
    drive(0, 1, 0);                       // read offered while empty
    #1 chk(out_valid == 0, "R4", "out_valid when empty", out_valid, 0);

    // ---- replay mode ----
    do_reset(1'b1);
    data_tag = "R2";
    for (int i = 0; i < 5; i++) drive(1, 0, 0);
    for (int i = 0; i < 3; i++) drive(0, 1, 0);
    data_tag = "R7";
    drive(0, 1, 1);                       // rewind with sink ready: blocked
    drive(0, 0, 0);
    #1;
    chk(empty == 0, "R10", "empty after rewind", empty, 0);
    chk(almost_empty == 0, "R10", "almost_empty after rewind", almost_empty, 0);
    chk(out_data == 16'hA000 + seq - 5, "R7", "first replayed word", out_data, 16'hA000 + seq - 5);
    data_tag = "R9";
    for (int i = 0; i < 3; i++) drive(1, 1, 0);
    for (int i = 0; i < 6; i++) drive(0, 1, 0);
    #1 chk(full == 1, "R3", "full after DEPTH accepted", full, 1);
    data_tag = "R11";
    for (int r = 0; r < 2; r++) begin
      drive(0, 0, 1);
      for (int i = 0; i < DEPTH + 1; i++) drive(1, 1, 0);
      #1 chk(empty == 1, "R11", "empty after full replay", empty, 1);
    end
    drive(0, 0, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule